// File: doc/BRIEF.md
# Floppy Interface IO Port Decoder

This block sits between the processor's IO bus and the peripheral chips of a floppy-disk interface. It looks at the low byte of the IO address (plus A8 to A11) and at the IORQ, M1, RD and WR strobes. From them it makes one chip select for each attached device: a real-time clock, a DMA controller, a floppy disk controller, a memory-control port and two parallel-port chips. It also passes on the address bits that pick a register inside those devices.

The decode is partial. A7 low is common to every device, and the five lowest address bits pick the device. A5 and A6 are ignored, except where they choose a register. One base address holds two write latches inside the block: the drive latch (motors and drive selects for four drives) and the density latch. A5 picks between them. An IN cycle to the drive latch address puts the external drive-status byte on the read data bus. No other IN cycle makes the block drive that bus.

Top module: `fdc_io_decode`

## Requirements
- R1: While A7 (`addr[7]`) is 1, every chip select is 0, `data_oe` is 0 and neither latch changes.
- R2: A chip select or `data_oe` can be 1 only while `iorq_n`=0 and `m1_n`=1. An interrupt acknowledge (`m1_n`=0) selects nothing. At most one chip select is 1 at any time.
- R3: `cs_rtc` is 1 for a qualified IO cycle whose low byte matches `0xx00011` (x means don't care). `rtc_reg` always equals `addr[11:8]`.
- R4: `cs_dma` is 1 for a qualified IO cycle whose low byte matches `0xx01011`. The low-byte pattern `0xx00111` drives no chip select.
- R5: `cs_fdc` is 1 for a qualified IO cycle whose low byte matches `0xx01111`. `dev_reg` always equals `addr[6:5]`.
- R6: `cs_ppi2` is 1 for low byte `0xx11011` and `cs_ppi1` is 1 for low byte `0xx11111`, in a qualified IO cycle. Both use `dev_reg` as their register select.
- R7: `cs_mem` is 1 for a qualified IO cycle whose low byte matches `0xx10111`, whatever A5 and A6 are.
- R8: At each rising clock edge of a qualified cycle with `wr_n`=0, one of two latches may load:
  - low byte `0x13` (pattern `00010011`): `drive_latch` loads `data_in`.
  - low byte `0x33` (pattern `00110011`): `density` loads `data_in[0]`, where 0 means double density and 1 means high density.
  - any other write, including `0x53` and `0x73`, changes neither latch.
- R9: In a qualified cycle with `rd_n`=0 and low byte `0x13`, `data_oe` is 1 and `data_out` equals `drive_status`, combinationally. In every other cycle, including IN to `0x33`, `data_oe` is 0 and `data_out` is 0.
- R10: While `rst_n` is 0, both latches are cleared at the clock edge: `drive_latch`=0 (all motors off, no drive selected) and `density`=0 (double density).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the two latches |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | IO address bits A11..A0 |
| iorq_n | input | 1 | IO request, active low |
| m1_n | input | 1 | Opcode fetch / interrupt acknowledge marker, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| data_in | input | 8 | Write data from the processor |
| drive_status | input | 8 | Status byte from the drives |
| data_out | output | 8 | Read data to the processor |
| data_oe | output | 1 | Drive enable for read data |
| cs_rtc | output | 1 | Real-time clock select |
| cs_dma | output | 1 | DMA controller select |
| cs_fdc | output | 1 | Floppy controller select |
| cs_mem | output | 1 | Memory-control port select |
| cs_ppi2 | output | 1 | Second parallel-port chip select |
| cs_ppi1 | output | 1 | First parallel-port chip select |
| rtc_reg | output | 4 | Clock register index (A11..A8) |
| dev_reg | output | 2 | Register index for the controller and parallel chips (A6..A5) |
| drive_latch | output | 8 | Motor and drive-select latch |
| density | output | 1 | Density latch, 1 = high density |

## Verification
The assertions assume that the bus strobes and the address are stable around each rising clock edge. They do not assume that RD and WR are exclusive, nor that an interrupt acknowledge keeps its address clean. The stimulus changes every input only at falling edges. It sweeps all 256 low-byte values through IN, OUT, interrupt-acknowledge and idle cycles, with random A8 to A11 and random data. It also drives reset in the middle of a run.

// File: rtl/fdc_io_pkg.sv
package fdc_io_pkg;

  localparam int NUM_DEV = 7;
  localparam int LOW_W   = 5;

  typedef enum logic [2:0] {
    DEV_RTC  = 3'd0,
    DEV_DMA  = 3'd1,
    DEV_FDC  = 3'd2,
    DEV_DRV  = 3'd3,
    DEV_MEM  = 3'd4,
    DEV_PPI2 = 3'd5,
    DEV_PPI1 = 3'd6
  } dev_e;

  // Five-bit low-address pattern for each device slot.
  function automatic logic [LOW_W-1:0] dev_pattern(input int idx);
    case (idx)
      int'(DEV_RTC):  return 5'b00011;
      int'(DEV_DMA):  return 5'b01011;
      int'(DEV_FDC):  return 5'b01111;
      int'(DEV_DRV):  return 5'b10011;
      int'(DEV_MEM):  return 5'b10111;
      int'(DEV_PPI2): return 5'b11011;
      default:        return 5'b11111;
    endcase
  endfunction

  // The drive-latch base also needs A6 low; A5 then picks the latch.
  function automatic logic dev_needs_a6_low(input int idx);
    return idx == int'(DEV_DRV);
  endfunction

  // A real IO transfer: IORQ asserted, not an interrupt acknowledge.
  function automatic logic io_qualified(input logic iorq_n, input logic m1_n);
    return !iorq_n && m1_n;
  endfunction

endpackage

// File: rtl/fdc_io_match.sv
module fdc_io_match
  import fdc_io_pkg::*;
#(
  parameter int N_DEV = NUM_DEV
) (
  input  logic [7:0]       addr_lo,
  input  logic             io_ok,
  output logic [N_DEV-1:0] hit
);

  logic base_ok;
  assign base_ok = io_ok && !addr_lo[7];

  for (genvar g = 0; g < N_DEV; g++) begin : g_dev
    logic low_match;
    logic a6_ok;
    assign low_match = (addr_lo[LOW_W-1:0] == dev_pattern(g));
    assign a6_ok     = !dev_needs_a6_low(g) || !addr_lo[6];
    assign hit[g]    = base_ok && low_match && a6_ok;
  end

endmodule

// File: rtl/fdc_io_latch.sv
module fdc_io_latch #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drv_wr,
  input  logic              den_wr,
  input  logic [DATA_W-1:0] data_in,
  output logic [DATA_W-1:0] drive_latch,
  output logic              density
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drive_latch <= '0;
      density     <= 1'b0;
    end else begin
      if (drv_wr) drive_latch <= data_in;
      if (den_wr) density     <= data_in[0];
    end
  end

endmodule

// File: rtl/fdc_io_readback.sv
module fdc_io_readback #(
  parameter int DATA_W = 8
) (
  input  logic              rd_hit,
  input  logic [DATA_W-1:0] drive_status,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe
);

  always_comb begin
    data_oe  = rd_hit;
    data_out = rd_hit ? drive_status : '0;
  end

endmodule

// File: rtl/fdc_io_decode.sv
module fdc_io_decode
  import fdc_io_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RTC_LSB   = 8,
  parameter int RTC_REG_W = 4,
  parameter int DEV_REG_W = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RTC_LSB+RTC_REG_W-1:0] addr,
  input  logic                 iorq_n,
  input  logic                 m1_n,
  input  logic                 rd_n,
  input  logic                 wr_n,
  input  logic [DATA_W-1:0]    data_in,
  input  logic [DATA_W-1:0]    drive_status,
  output logic [DATA_W-1:0]    data_out,
  output logic                 data_oe,
  output logic                 cs_rtc,
  output logic                 cs_dma,
  output logic                 cs_fdc,
  output logic                 cs_mem,
  output logic                 cs_ppi2,
  output logic                 cs_ppi1,
  output logic [RTC_REG_W-1:0] rtc_reg,
  output logic [DEV_REG_W-1:0] dev_reg,
  output logic [DATA_W-1:0]    drive_latch,
  output logic                 density
);

  localparam int DEV_REG_LSB = 5;
  localparam int LATCH_SEL   = 5;

  // Named internal events, used by the checker.
  logic               io_ok;
  logic [NUM_DEV-1:0] hit;
  logic               drv_base_hit;
  logic               drv_wr_hit;
  logic               den_wr_hit;
  logic               stat_rd_hit;

  assign io_ok = io_qualified(iorq_n, m1_n);

  fdc_io_match #(.N_DEV(NUM_DEV)) u_match (
    .addr_lo (addr[7:0]),
    .io_ok   (io_ok),
    .hit     (hit)
  );

  assign drv_base_hit = hit[DEV_DRV];
  assign drv_wr_hit   = drv_base_hit && !addr[LATCH_SEL] && !wr_n;
  assign den_wr_hit   = drv_base_hit &&  addr[LATCH_SEL] && !wr_n;
  assign stat_rd_hit  = drv_base_hit && !addr[LATCH_SEL] && !rd_n;

  assign cs_rtc  = hit[DEV_RTC];
  assign cs_dma  = hit[DEV_DMA];
  assign cs_fdc  = hit[DEV_FDC];
  assign cs_mem  = hit[DEV_MEM];
  assign cs_ppi2 = hit[DEV_PPI2];
  assign cs_ppi1 = hit[DEV_PPI1];

  assign rtc_reg = addr[RTC_LSB +: RTC_REG_W];
  assign dev_reg = addr[DEV_REG_LSB +: DEV_REG_W];

  fdc_io_latch #(.DATA_W(DATA_W)) u_latch (
    .clk         (clk),
    .rst_n       (rst_n),
    .drv_wr      (drv_wr_hit),
    .den_wr      (den_wr_hit),
    .data_in     (data_in),
    .drive_latch (drive_latch),
    .density     (density)
  );

  fdc_io_readback #(.DATA_W(DATA_W)) u_rb (
    .rd_hit       (stat_rd_hit),
    .drive_status (drive_status),
    .data_out     (data_out),
    .data_oe      (data_oe)
  );

endmodule

// File: rtl/fdc_io_decode_chk.sv
module fdc_io_decode_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [11:0] addr,
  input logic        iorq_n,
  input logic        m1_n,
  input logic        rd_n,
  input logic [7:0]  data_in,
  input logic [7:0]  drive_status,
  input logic [7:0]  data_out,
  input logic        data_oe,
  input logic [5:0]  sel,
  input logic [7:0]  drive_latch,
  input logic        density,
  input logic        drv_wr_hit,
  input logic        den_wr_hit
);

  assert_a7_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr[7] |-> (sel == 6'd0) && !data_oe);

  assert_a7_no_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    addr[7] |=> $stable(drive_latch) && $stable(density));

  assert_iack_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!m1_n || iorq_n) |-> (sel == 6'd0) && !data_oe);

  assert_one_select_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  assert_drive_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drv_wr_hit |=> drive_latch == $past(data_in));

  assert_drive_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_wr_hit |=> $stable(drive_latch));

  assert_density_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !den_wr_hit |=> $stable(density));

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (data_out == drive_status) && !rd_n && !iorq_n);

  assert_idle_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_oe |-> data_out == 8'd0);

  assert_reset_clear_R10: assert property (@(posedge clk)
    !rst_n |=> (drive_latch == 8'd0) && !density);

endmodule

bind fdc_io_decode fdc_io_decode_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .iorq_n       (iorq_n),
  .m1_n         (m1_n),
  .rd_n         (rd_n),
  .data_in      (data_in),
  .drive_status (drive_status),
  .data_out     (data_out),
  .data_oe      (data_oe),
  .sel          ({cs_rtc, cs_dma, cs_fdc, cs_mem, cs_ppi2, cs_ppi1}),
  .drive_latch  (drive_latch),
  .density      (density),
  .drv_wr_hit   (drv_wr_hit),
  .den_wr_hit   (den_wr_hit)
);

// File: tb/test_fdc_io_decode.sv
`timescale 1ns/100ps
module test_fdc_io_decode;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [7:0]  data_in = '0, drive_status = '0;
  logic [7:0]  data_out, drive_latch;
  logic        data_oe, cs_rtc, cs_dma, cs_fdc, cs_mem, cs_ppi2, cs_ppi1, density;
  logic [3:0]  rtc_reg;
  logic [1:0]  dev_reg;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fdc_io_decode i_fdc_io_decode (
    .clk(clk), .rst_n(rst_n), .addr(addr), .iorq_n(iorq_n), .m1_n(m1_n),
    .rd_n(rd_n), .wr_n(wr_n), .data_in(data_in), .drive_status(drive_status),
    .data_out(data_out), .data_oe(data_oe), .cs_rtc(cs_rtc), .cs_dma(cs_dma),
    .cs_fdc(cs_fdc), .cs_mem(cs_mem), .cs_ppi2(cs_ppi2), .cs_ppi1(cs_ppi1),
    .rtc_reg(rtc_reg), .dev_reg(dev_reg), .drive_latch(drive_latch),
    .density(density)
  );

  // Behavioural reference state.
  logic [7:0] m_drive = '0;
  logic       m_den   = 1'b0;

  function automatic bit is_io();
    return (iorq_n == 1'b0) && (m1_n == 1'b1);
  endfunction

  // Expected device by low byte: 1 rtc,2 dma,3 fdc,4 mem,5 ppi2,6 ppi1,
  // 7 drive latch, 8 density latch, 0 nothing.
  function automatic int which_dev(input logic [7:0] lo);
    casez (lo)
      8'b0??00011: return 1;
      8'b0??01011: return 2;
      8'b0??01111: return 3;
      8'b0??10111: return 4;
      8'b0??11011: return 5;
      8'b0??11111: return 6;
      8'b00010011: return 7;
      8'b00110011: return 8;
      default:     return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_drive <= 8'h00;
      m_den   <= 1'b0;
    end else if (is_io() && !wr_n) begin
      if (which_dev(addr[7:0]) == 7) m_drive <= data_in;
      if (which_dev(addr[7:0]) == 8) m_den   <= data_in[0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at addr=%h: actual=%h expected=%h", tag, addr, act, exp);
    end
  endtask

  task automatic compare_all();
    int  d;
    bit  q;
    bit  rdhit;
    q     = is_io();
    d     = q ? which_dev(addr[7:0]) : 0;
    rdhit = (d == 7) && !rd_n;
    chk("R3 cs_rtc",  cs_rtc,  d == 1);
    chk("R3 rtc_reg", rtc_reg, addr[11:8]);
    chk("R4 cs_dma",  cs_dma,  d == 2);
    chk("R5 cs_fdc",  cs_fdc,  d == 3);
    chk("R5 dev_reg", dev_reg, addr[6:5]);
    chk("R7 cs_mem",  cs_mem,  d == 4);
    chk("R6 cs_ppi2", cs_ppi2, d == 5);
    chk("R6 cs_ppi1", cs_ppi1, d == 6);
    chk("R9 data_oe", data_oe, rdhit);
    chk("R9 data_out", data_out, rdhit ? drive_status : 8'h00);
    chk("R8 drive_latch", drive_latch, m_drive);
    chk("R8 density", density, m_den);
    if (addr[7] || !q)
      chk(addr[7] ? "R1 quiet" : "R2 quiet",
          {cs_rtc, cs_dma, cs_fdc, cs_mem, cs_ppi2, cs_ppi1, data_oe}, 0);
  endtask

  task automatic step(input logic [11:0] a, input logic iorq, input logic m1,
                      input logic rd, input logic wr, input logic [7:0] din,
                      input logic [7:0] st);
    @(negedge clk);
    addr = a; iorq_n = iorq; m1_n = m1; rd_n = rd; wr_n = wr;
    data_in = din; drive_status = st;
    #1.5 compare_all();
  endtask

  task automatic idle();
    step(12'h000, 1'b1, 1'b1, 1'b1, 1'b1, 8'h00, 8'h00);
  endtask

  initial begin
    // Reset state, R10.
    repeat (3) idle();
    chk("R10 reset drive_latch", drive_latch, 8'h00);
    chk("R10 reset density", density, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle();

    // Directed: drive latch, density, mirrors and ignored writes (R8, R9).
    step(12'h013, 0, 1, 1, 0, 8'hA5, 8'h00);
    idle();
    chk("R8 drive load", drive_latch, 8'hA5);
    step(12'h033, 0, 1, 1, 0, 8'h01, 8'h00);
    idle();
    chk("R8 density high", density, 1'b1);
    step(12'h053, 0, 1, 1, 0, 8'h3C, 8'h00);
    step(12'h093, 0, 1, 1, 0, 8'h3C, 8'h00);
    step(12'h013, 0, 0, 1, 0, 8'h3C, 8'h00);
    idle();
    chk("R8 ignored writes", drive_latch, 8'hA5);
    step(12'h033, 0, 1, 0, 1, 8'h00, 8'h77);
    chk("R9 no read at density port", data_oe, 1'b0);
    step(12'h713, 0, 1, 0, 1, 8'h00, 8'hC3);
    chk("R9 status read", data_out, 8'hC3);
    step(12'h00B, 0, 1, 1, 0, 8'h00, 8'h00);
    chk("R4 dma at 0x0B", cs_dma, 1'b1);
    step(12'h007, 0, 1, 1, 0, 8'h00, 8'h00);
    chk("R4 unused 0x07", cs_dma | cs_rtc | cs_mem, 1'b0);

    // Sweeps over every low byte in four cycle kinds.
    for (int k = 0; k < 4; k++) begin
      for (int lo = 0; lo < 256; lo++) begin
        logic [3:0] hi;
        logic [7:0] dv, sv;
        hi = 4'($urandom_range(0, 15));
        dv = 8'($urandom_range(0, 255));
        sv = 8'($urandom_range(0, 255));
        case (k)
          0: step({hi, 8'(lo)}, 0, 1, 0, 1, dv, sv);
          1: step({hi, 8'(lo)}, 0, 1, 1, 0, dv, sv);
          2: step({hi, 8'(lo)}, 0, 0, 0, 0, dv, sv);
          default: step({hi, 8'(lo)}, 1, 1, 0, 0, dv, sv);
        endcase
      end
    end

    // Mid-run reset, R10.
    step(12'h013, 0, 1, 1, 0, 8'hFF, 8'h00);
    step(12'h033, 0, 1, 1, 0, 8'hFF, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    idle();
    chk("R10 mid reset drive_latch", drive_latch, 8'h00);
    chk("R10 mid reset density", density, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    idle();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule